// File: doc/BRIEF.md
# Multicore Interrupt Router with Inter-Processor Signalling

This block steers a vector of external interrupt lines to the interrupt pins of up to four cores in a shared-memory cluster. Every external line carries its own core-selection mask, so it can reach any subset of cores, including none of them or all of them. A line reaches a core only when the line is enabled, the core is enabled, and the core's bit is set in that line's mask. A per-line software-assert bit makes a line look active while its physical input is low.

Each core also owns sixteen inter-processor request bits. Any core sets or clears them with a single mask write, so no read-modify-write is needed. For each core, a programmable mask per IPI pin selects which request bits feed each of three reserved pins. All interrupt outputs are registered. Configuration and state are reached through a synchronous register port, and read data appears one cycle after the read strobe.

Top module: `irq_cluster_router`

## Requirements
- R1: External line i, when it passes all gates, drives bit i of the target core's pin group and no other bit. Core c's group occupies `core_irq_o[c*(NL+3) +: NL+3]`.
- R2: The mask at address 0x10+i gives the cores that may receive line i: bit c selects core c. Any subset is legal.
- R3: Line-enable register 0x01 (bit i for line i). A clear bit blocks that line from every core.
- R4: Core-enable register 0x00 (bit c for core c). A clear bit blocks every external line from core c. IPI pins are not affected.
- R5: Software-assert bits are set by writing ones to 0x02 and cleared by writing ones to 0x03. A set bit makes line i active even with its input low. Both addresses read back the current bits.
- R6: Core c has 16 IPI bits. Writing ones to 0x20+c sets bits and writing ones to 0x28+c clears bits. Other bits keep their value. Both addresses read back the bits.
- R7: IPI pin p (0..2) of core c sits at bit NL+p of that core's group. It equals the OR over k of (IPI bit k AND bit k of the map register at 0x40+4*c+p).
- R8: Every interrupt output is registered. It reflects the inputs and register contents that were present one rising edge earlier.
- R9: A synchronous active-high reset clears all enables, masks, software-assert bits, IPI bits, maps, outputs and read data.
- R10: A read strobe at an address returns the register value, zero-extended, on `reg_rdata_o` after the next edge. With no strobe, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | NUM_LINES | Physical external interrupt lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| core_irq_o | output | NUM_CORES*(NUM_LINES+3) | Per-core interrupt pin groups |

## Verification
An external line and an IPI pin of the same core can change in the same cycle, because a line input and an IPI-set write are independent paths. The bench provokes this by raising physical lines in the same cycle that it writes an IPI set mask for that core. It then checks that the whole pin group matches the independent model on the next cycle. A software-assert write that coincides with the matching physical line going high is judged the same way: the line must appear exactly once and exactly one cycle later.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned AW       = 8;
  localparam int unsigned DW       = 32;
  localparam int unsigned IPI_BITS = 16;
  localparam int unsigned IPI_PINS = 3;

  localparam logic [AW-1:0] A_CORE_EN = 8'h00;
  localparam logic [AW-1:0] A_LINE_EN = 8'h01;
  localparam logic [AW-1:0] A_SW_SET  = 8'h02;
  localparam logic [AW-1:0] A_SW_CLR  = 8'h03;
  localparam logic [AW-1:0] A_ROUTE   = 8'h10;
  localparam logic [AW-1:0] A_IPI_SET = 8'h20;
  localparam logic [AW-1:0] A_IPI_CLR = 8'h28;
  localparam logic [AW-1:0] A_IPI_MAP = 8'h40;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NC = 4,
  parameter int unsigned NL = 8
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     we,
  input  logic                                     re,
  input  logic [AW-1:0]                            addr,
  input  logic [DW-1:0]                            wdata,
  output logic [DW-1:0]                            rdata,
  output logic [NC-1:0]                            core_en,
  output logic [NL-1:0]                            line_en,
  output logic [NL-1:0]                            sw_on,
  output logic [NL-1:0][NC-1:0]                    route,
  output logic [NC-1:0][IPI_BITS-1:0]              ipi,
  output logic [NC-1:0][IPI_PINS-1:0][IPI_BITS-1:0] ipi_map
);
  logic [IPI_BITS-1:0] wmask;
  logic                unused_wdata;
  assign wmask        = wdata[IPI_BITS-1:0];
  assign unused_wdata = ^wdata[DW-1:IPI_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      core_en <= '0;
      line_en <= '0;
      sw_on   <= '0;
      route   <= '0;
      ipi     <= '0;
      ipi_map <= '0;
    end else if (we) begin
      if (addr == A_CORE_EN) core_en <= wdata[NC-1:0];
      if (addr == A_LINE_EN) line_en <= wdata[NL-1:0];
      if (addr == A_SW_SET)  sw_on   <= sw_on | wdata[NL-1:0];
      if (addr == A_SW_CLR)  sw_on   <= sw_on & ~wdata[NL-1:0];
      for (int i = 0; i < NL; i++)
        if (addr == AW'(A_ROUTE + i)) route[i] <= wdata[NC-1:0];
      for (int c = 0; c < NC; c++) begin
        if (addr == AW'(A_IPI_SET + c)) ipi[c] <= ipi[c] | wmask;
        if (addr == AW'(A_IPI_CLR + c)) ipi[c] <= ipi[c] & ~wmask;
        for (int p = 0; p < IPI_PINS; p++)
          if (addr == AW'(A_IPI_MAP + 4 * c + p)) ipi_map[c][p] <= wmask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (re) begin
        if (addr == A_CORE_EN) rdata <= DW'(core_en);
        if (addr == A_LINE_EN) rdata <= DW'(line_en);
        if (addr == A_SW_SET || addr == A_SW_CLR) rdata <= DW'(sw_on);
        for (int i = 0; i < NL; i++)
          if (addr == AW'(A_ROUTE + i)) rdata <= DW'(route[i]);
        for (int c = 0; c < NC; c++) begin
          if (addr == AW'(A_IPI_SET + c) || addr == AW'(A_IPI_CLR + c))
            rdata <= DW'(ipi[c]);
          for (int p = 0; p < IPI_PINS; p++)
            if (addr == AW'(A_IPI_MAP + 4 * c + p)) rdata <= DW'(ipi_map[c][p]);
        end
      end
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) $fell(rst) |->
    (core_en == '0 && line_en == '0 && sw_on == '0 && route == '0 &&
     ipi == '0 && ipi_map == '0 && rdata == '0)); // R9

  for (genvar c = 0; c < NC; c++) begin : g_ipi_chk
    AST_IPI_W1S: assert property (@(posedge clk) disable iff (rst)
      (we && addr == AW'(A_IPI_SET + c)) |=>
      ((ipi[c] & $past(wmask)) == $past(wmask))); // R6
    AST_IPI_W1C: assert property (@(posedge clk) disable iff (rst)
      (we && addr == AW'(A_IPI_CLR + c)) |=>
      ((ipi[c] & $past(wmask)) == '0)); // R6
  end
endmodule

// File: rtl/irq_router_dist.sv
module irq_router_dist #(
  parameter int unsigned NC = 4,
  parameter int unsigned NL = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NL-1:0]         lines,
  input  logic [NL-1:0]         sw_on,
  input  logic [NL-1:0]         line_en,
  input  logic [NC-1:0]         core_en,
  input  logic [NL-1:0][NC-1:0] route,
  output logic [NC-1:0][NL-1:0] ext_q
);
  logic [NC-1:0][NL-1:0] col;
  logic [NL-1:0]         active;

  assign active = (lines | sw_on) & line_en;

  for (genvar c = 0; c < NC; c++) begin : g_col
    for (genvar i = 0; i < NL; i++) begin : g_bit
      assign col[c][i] = route[i][c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= '0;
    end else begin
      for (int c = 0; c < NC; c++)
        ext_q[c] <= active & col[c] & {NL{core_en[c]}};
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_chk
    AST_CORE_GATE: assert property (@(posedge clk) disable iff (rst)
      !$past(core_en[c]) |-> ext_q[c] == '0); // R4
    AST_LINE_GATE: assert property (@(posedge clk) disable iff (rst)
      (ext_q[c] & ~$past(line_en)) == '0); // R3
    AST_ROUTE_GATE: assert property (@(posedge clk) disable iff (rst)
      (ext_q[c] & ~$past(col[c])) == '0); // R2
    AST_SOURCE_GATE: assert property (@(posedge clk) disable iff (rst)
      (ext_q[c] & ~$past(lines | sw_on)) == '0); // R1
  end
endmodule

// File: rtl/irq_router_ipi.sv
module irq_router_ipi
  import irq_router_pkg::*;
#(
  parameter int unsigned NC = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [NC-1:0][IPI_BITS-1:0]               ipi,
  input  logic [NC-1:0][IPI_PINS-1:0][IPI_BITS-1:0] ipi_map,
  output logic [NC-1:0][IPI_PINS-1:0]               pins_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
    end else begin
      for (int c = 0; c < NC; c++)
        for (int p = 0; p < IPI_PINS; p++)
          pins_q[c][p] <= |(ipi[c] & ipi_map[c][p]);
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_chk
    AST_IPI_IDLE: assert property (@(posedge clk) disable iff (rst)
      ($past(ipi[c]) == '0) |-> pins_q[c] == '0); // R7
    for (genvar p = 0; p < IPI_PINS; p++) begin : g_pin
      AST_IPI_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        ($past(ipi_map[c][p]) == '0) |-> !pins_q[c][p]); // R7
    end
  end
endmodule

// File: rtl/irq_cluster_router.sv
module irq_cluster_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [NUM_LINES-1:0]                    irq_lines_i,
  input  logic                                    reg_we_i,
  input  logic                                    reg_re_i,
  input  logic [7:0]                              reg_addr_i,
  input  logic [31:0]                             reg_wdata_i,
  output logic [31:0]                             reg_rdata_o,
  output logic [NUM_CORES*(NUM_LINES+3)-1:0]      core_irq_o
);
  localparam int unsigned PW = NUM_LINES + IPI_PINS;

  logic [NUM_CORES-1:0]                             core_en;
  logic [NUM_LINES-1:0]                             line_en;
  logic [NUM_LINES-1:0]                             sw_on;
  logic [NUM_LINES-1:0][NUM_CORES-1:0]              route;
  logic [NUM_CORES-1:0][IPI_BITS-1:0]               ipi;
  logic [NUM_CORES-1:0][IPI_PINS-1:0][IPI_BITS-1:0] ipi_map;
  logic [NUM_CORES-1:0][NUM_LINES-1:0]              ext_q;
  logic [NUM_CORES-1:0][IPI_PINS-1:0]               pins_q;

  irq_router_regs #(.NC(NUM_CORES), .NL(NUM_LINES)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we_i), .re(reg_re_i),
    .addr(reg_addr_i), .wdata(reg_wdata_i), .rdata(reg_rdata_o),
    .core_en(core_en), .line_en(line_en), .sw_on(sw_on),
    .route(route), .ipi(ipi), .ipi_map(ipi_map)
  );

  irq_router_dist #(.NC(NUM_CORES), .NL(NUM_LINES)) u_dist (
    .clk(clk), .rst(rst), .lines(irq_lines_i), .sw_on(sw_on),
    .line_en(line_en), .core_en(core_en), .route(route), .ext_q(ext_q)
  );

  irq_router_ipi #(.NC(NUM_CORES)) u_ipi (
    .clk(clk), .rst(rst), .ipi(ipi), .ipi_map(ipi_map), .pins_q(pins_q)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_out
    assign core_irq_o[c*PW +: NUM_LINES]           = ext_q[c];
    assign core_irq_o[c*PW + NUM_LINES +: IPI_PINS] = pins_q[c];
  end

  AST_OUT_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $fell(rst) |-> core_irq_o == '0); // R8
endmodule

// File: tb/sim_irq_cluster_router.sv
module sim_irq_cluster_router;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int PW = NL + 3;
  localparam int OW = NC * PW;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [OW-1:0] out;
    logic [31:0]   rd;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] lines = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [OW-1:0] irq;

  item_t q[$];
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;

  logic          m_rst = 1'b1;
  logic [NL-1:0] cur_lines = '0;
  logic [NC-1:0] m_cen;
  logic [NL-1:0] m_len, m_sw;
  logic [NC-1:0] m_route [NL];
  logic [15:0]   m_ipi [NC];
  logic [15:0]   m_map [NC][3];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cluster_router #(.NUM_CORES(NC), .NUM_LINES(NL)) u0 (
    .clk(clk), .rst(rst), .irq_lines_i(lines), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .core_irq_o(irq)
  );

  function automatic void model_clear();
    m_cen = '0; m_len = '0; m_sw = '0;
    for (int i = 0; i < NL; i++) m_route[i] = '0;
    for (int c = 0; c < NC; c++) begin
      m_ipi[c] = '0;
      for (int p = 0; p < 3; p++) m_map[c][p] = '0;
    end
  endfunction

  function automatic logic [OW-1:0] model_out(input logic [NL-1:0] ln);
    logic [OW-1:0] o = '0;
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < NL; i++)
        o[c*PW + i] = (ln[i] | m_sw[i]) & m_len[i] & m_cen[c] & m_route[i][c];
      for (int p = 0; p < 3; p++)
        o[c*PW + NL + p] = |(m_ipi[c] & m_map[c][p]);
    end
    return o;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h00) r = 32'(m_cen);
    if (a == 8'h01) r = 32'(m_len);
    if (a == 8'h02 || a == 8'h03) r = 32'(m_sw);
    for (int i = 0; i < NL; i++) if (a == 8'(16 + i)) r = 32'(m_route[i]);
    for (int c = 0; c < NC; c++) begin
      if (a == 8'(32 + c) || a == 8'(40 + c)) r = 32'(m_ipi[c]);
      for (int p = 0; p < 3; p++) if (a == 8'(64 + 4*c + p)) r = 32'(m_map[c][p]);
    end
    return r;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h00) m_cen = d[NC-1:0];
    if (a == 8'h01) m_len = d[NL-1:0];
    if (a == 8'h02) m_sw = m_sw | d[NL-1:0];
    if (a == 8'h03) m_sw = m_sw & ~d[NL-1:0];
    for (int i = 0; i < NL; i++) if (a == 8'(16 + i)) m_route[i] = d[NC-1:0];
    for (int c = 0; c < NC; c++) begin
      if (a == 8'(32 + c)) m_ipi[c] = m_ipi[c] | d[15:0];
      if (a == 8'(40 + c)) m_ipi[c] = m_ipi[c] & ~d[15:0];
      for (int p = 0; p < 3; p++) if (a == 8'(64 + 4*c + p)) m_map[c][p] = d[15:0];
    end
  endfunction

  // driver: one register-port cycle, expected result pushed to the scoreboard
  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic r, input string tag);
    item_t it;
    @(negedge clk);
    rst <= m_rst; we <= w; addr <= a; wdata <= d; re <= r; lines <= cur_lines;
    if (m_rst) begin
      model_clear();
      it.out = '0; it.rd = '0;
    end else begin
      it.out = model_out(cur_lines);
      it.rd  = r ? model_read(a) : 32'h0;
      if (w) model_write(a, d);
    end
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 8'h00, 32'h0, 1'b0, tag);
  endtask

  // monitor: compares after each edge that follows a pushed cycle
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      n_vec++;
      if (irq !== it.out || rdata !== it.rd) begin
        n_bad++;
        $display("FAIL %s: irq=%h rdata=%h expected irq=%h rdata=%h",
                 it.tag, irq, rdata, it.out, it.rd);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    // R9: reset holds everything at zero even with lines high
    m_rst = 1'b1; cur_lines = '1;
    repeat (3) idle("R9 reset outputs");
    m_rst = 1'b0;
    idle("R9 after reset lines high");
    cyc(0, 8'h00, 0, 1, "R10 R9 core enable reads zero");
    cyc(0, 8'h10, 0, 1, "R10 R9 route reads zero");
    cyc(0, 8'h41, 0, 1, "R10 R9 map reads zero");
    cur_lines = '0;
    // configure routing
    cyc(1, 8'h00, 32'hF, 0, "R4 core enable all");
    cyc(1, 8'h01, 32'hFF, 0, "R3 line enable all");
    for (int i = 0; i < NL; i++)
      cyc(1, 8'(16 + i), 32'((i * 5 + 1) & 15), 0, "R2 route write");
    cyc(1, 8'h12, 32'h0, 0, "R2 empty subset");
    cyc(1, 8'h13, 32'hF, 0, "R2 full subset");
    for (int i = 0; i < NL; i++)
      cyc(0, 8'(16 + i), 0, 1, "R10 route readback");
    // R1 R2 line patterns
    cur_lines = 8'h01; idle("R1 single line");
    cur_lines = 8'hAA; idle("R1 R2 odd lines");
    cur_lines = 8'h55; idle("R1 R2 even lines");
    cur_lines = 8'hFF; idle("R2 all lines");
    // R8 one-cycle pulse appears exactly one edge later and then drops
    cur_lines = 8'h10; idle("R8 pulse in");
    cur_lines = 8'h00; idle("R8 pulse out");
    idle("R8 pulse gone");
    // R3 line enable
    cur_lines = 8'hFF;
    cyc(1, 8'h01, 32'hF7, 0, "R3 disable line 3");
    idle("R3 line 3 blocked"); idle("R3 line 3 blocked hold");
    // R4 core enable
    cyc(1, 8'h00, 32'hD, 0, "R4 disable core 1");
    idle("R4 core 1 blocked");
    cyc(0, 8'h00, 0, 1, "R10 core enable readback");
    cyc(1, 8'h00, 32'hF, 0, "R4 core 1 restored");
    cyc(1, 8'h01, 32'hFF, 0, "R3 restore");
    // R5 software assert
    cur_lines = 8'h00;
    cyc(1, 8'h02, 32'h22, 0, "R5 soft set");
    idle("R5 soft lines active");
    cyc(1, 8'h02, 32'h80, 0, "R5 soft set adds");
    cyc(0, 8'h03, 0, 1, "R5 soft readback");
    cyc(1, 8'h03, 32'h02, 0, "R5 soft clear one");
    idle("R5 soft after clear");
    cyc(0, 8'h02, 0, 1, "R5 soft readback after clear");
    cyc(1, 8'h03, 32'hFF, 0, "R5 soft clear all");
    // R6 R7 IPI
    cyc(1, 8'h40, 32'h0001, 0, "R7 map core0 pin0");
    cyc(1, 8'h41, 32'h8001, 0, "R7 map core0 pin1");
    cyc(1, 8'h42, 32'h00F0, 0, "R7 map core0 pin2");
    cyc(1, 8'h48, 32'hFFFF, 0, "R7 map core2 pin0");
    cyc(1, 8'h49, 32'h0100, 0, "R7 map core2 pin1");
    cyc(1, 8'h20, 32'h8000, 0, "R6 set core0 bit15");
    idle("R7 core0 pin1 only");
    cyc(1, 8'h20, 32'h0010, 0, "R6 set core0 bit4");
    idle("R7 core0 pins 1 and 2");
    cyc(1, 8'h28, 32'h8000, 0, "R6 clear core0 bit15");
    idle("R7 core0 pin2 only");
    cyc(0, 8'h20, 0, 1, "R6 core0 readback");
    cyc(0, 8'h28, 0, 1, "R6 core0 readback via clear addr");
    cyc(1, 8'h22, 32'h0101, 0, "R6 set core2");
    idle("R7 core2 pins");
    cyc(1, 8'h2A, 32'hFFFF, 0, "R6 clear core2");
    idle("R7 core2 quiet");
    // concurrency: external lines and IPI on the same core in one cycle
    cur_lines = 8'h03;
    cyc(1, 8'h20, 32'h0001, 0, "R1 R7 concurrent line and ipi");
    cur_lines = 8'h00;
    idle("R7 concurrent result");
    cur_lines = 8'h04;
    cyc(1, 8'h02, 32'h04, 0, "R5 soft set with physical line");
    cur_lines = 8'h00;
    idle("R5 soft holds line");
    // R9 reset in mid-run
    m_rst = 1'b1; idle("R9 mid reset"); idle("R9 mid reset hold");
    m_rst = 1'b0; cur_lines = '1;
    idle("R9 outputs zero after reset");
    cyc(0, 8'h02, 0, 1, "R9 soft cleared");
    cyc(0, 8'h20, 0, 1, "R9 ipi cleared");
    cyc(0, 8'h40, 0, 1, "R9 map cleared");
    cyc(0, 8'h01, 0, 1, "R9 line enable cleared");
    idle("R10 no strobe reads zero");
    @(posedge clk); #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule